// File: doc/BRIEF.md
# Serial Wiper Command Decoder

This block is the serial slave front end of a four-channel digital wiper controller. A host opens a frame by pulling chip select low. The block then takes in an identification byte and an instruction byte, and for some instructions a third byte that goes in or out. The identification byte must carry a fixed device-type nibble and the two pin-strapped address bits, or the frame is ignored. The instruction byte gives an opcode, a data-register index and a channel. The block turns this into strobes for a register bank that sits next to it. It also drives a serial output with a separate enable, so the pad can be made high-impedance.

Three frame lengths are decoded from the opcode. Stores and transfers produce one command strobe when chip select rises, and only when the bit count is exactly right. Reads request a word from the bank as soon as the instruction byte is complete, then shift that word out MSB first. One opcode switches the frame into stepping mode, where each further SCK rising edge is passed through as a wiper step. A hold input pauses the frame without losing its state.

All serial inputs are sampled on a fast system clock. They are assumed to be synchronous and free of glitches already.

Top module: `pot_spi_cmd_decoder`

## Requirements
- R1: After reset, so_en, cmd_valid, rd_req and step_valid are low. No bit is accepted until cs_n has been seen going from high to low, so a frame clocked in with cs_n held low straight out of reset produces no strobe.
- R2: The first byte of a frame, MSB first, must equal {4'b0101, 2'b00, strap[1], strap[0]}. On any mismatch the frame produces no cmd_valid, no rd_req, no step_valid and leaves so_en low.
- R3: The second byte is split as opcode in bits [7:4], data-register index in bits [3:2] and channel in bits [1:0]. These appear on sel_op, sel_dreg and sel_chan and hold there through the strobes that follow.
- R4: Opcodes 4'b1010 (store wiper) and 4'b1100 (store data register) give one cmd_valid pulse in the clock after cs_n rises, with cmd_wdata equal to the third byte, only if exactly 24 bits were clocked in.
- R5: The transfer opcodes 4'b1101, 4'b1110, 4'b0001 and 4'b1000 give one cmd_valid pulse when cs_n rises, only if exactly 16 bits were clocked in.
- R6: Opcodes 4'b1001 (fetch wiper) and 4'b1011 (fetch data register) give one rd_req pulse after the 16th SCK rising edge. rd_data is taken one clock after rd_req. It is shifted out MSB first on so_bit, changing on each SCK falling edge, starting from the falling edge that follows the 16th rising edge.
- R7: Opcode 4'b0101 shifts out the byte {7'b0, wip}, with wip sampled at the 16th rising edge. It raises no rd_req.
- R8: After opcode 4'b0010, every SCK rising edge from the 17th on gives one step_valid pulse, with step_up equal to SI at that edge. This goes on until cs_n rises, and the frame never raises cmd_valid.
- R9: Any opcode not listed in R4 to R8 raises no strobe of any kind.
- R10: hold_n taken low while SCK is low pauses the frame. SCK edges are then ignored and so_en is low. hold_n taken high while SCK is low resumes the frame with all of its state kept.
- R11: so_en is low within one clock of cs_n being high. It is high during the data byte of a matched fetch or status frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 2 | Pin-strapped address bits |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wip | input | 1 | Write-in-progress flag from the bank |
| rd_data | input | 8 | Bank read word, valid one clock after rd_req |
| so_bit | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for the so pad |
| rd_req | output | 1 | Read request pulse |
| sel_op | output | 4 | Decoded opcode |
| sel_chan | output | 2 | Selected channel |
| sel_dreg | output | 2 | Selected data register |
| cmd_valid | output | 1 | Store or transfer strobe |
| cmd_wdata | output | 8 | Write data for store opcodes |
| step_valid | output | 1 | Wiper step pulse |
| step_up | output | 1 | Step direction, 1 means up |

## Verification
If the bit counter drifts by even one position, the error shows at the ports within that frame. A store then never strobes, because the count at chip-select rise misses 16 or 24. A fetch shifts out a byte that is rotated by one. A latched identification result that is wrong, or a pause flag left over from an earlier frame, shows up in the next frame as a strobe or a missing strobe, or as so_en going high during a pause. The bench checks every frame's strobe counts, fields and shifted-out data against a model built from the requirements, within a few clocks of cs_n rising.

// File: rtl/pot_cmd_pkg.sv
`timescale 1ns/1ps
package pot_cmd_pkg;
  localparam int BYTE_W   = 8;
  localparam int HDR_BITS = 2 * BYTE_W;
  localparam int FULL_BITS = 3 * BYTE_W;

  typedef enum logic [3:0] {
    OP_GXFR_D2W = 4'b0001,
    OP_STEP     = 4'b0010,
    OP_STATUS   = 4'b0101,
    OP_GXFR_W2D = 4'b1000,
    OP_RD_WIPER = 4'b1001,
    OP_WR_WIPER = 4'b1010,
    OP_RD_DREG  = 4'b1011,
    OP_WR_DREG  = 4'b1100,
    OP_XFR_D2W  = 4'b1101,
    OP_XFR_W2D  = 4'b1110
  } pot_op_e;

  // Number of bits a strobing frame must carry; 0 for opcodes that never strobe.
  function automatic int store_bits(logic [3:0] op);
    case (op)
      OP_WR_WIPER, OP_WR_DREG: return FULL_BITS;
      OP_XFR_D2W, OP_XFR_W2D, OP_GXFR_D2W, OP_GXFR_W2D: return HDR_BITS;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_store(logic [3:0] op);
    return store_bits(op) != 0;
  endfunction

  function automatic logic is_fetch(logic [3:0] op);
    return (op == OP_RD_WIPER) || (op == OP_RD_DREG);
  endfunction
endpackage

// File: rtl/pot_spi_pins.sv
`timescale 1ns/1ps
module pot_spi_pins (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic armed,
  output logic paused
);
  logic cs_q, sck_q, live;

  // cs_q resets low so a select already held low at reset is not a falling edge.
  assign cs_fall  = cs_q & ~cs_n;
  assign cs_rise  = ~cs_q & cs_n;
  assign live     = armed & ~cs_n & ~paused;
  assign sck_rise = live & ~sck_q & sck;
  assign sck_fall = live & sck_q & ~sck;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b0;
      sck_q  <= 1'b0;
      armed  <= 1'b0;
      paused <= 1'b0;
    end else begin
      cs_q  <= cs_n;
      sck_q <= sck;
      if (cs_fall) armed <= 1'b1;
      if (cs_n) paused <= 1'b0;
      else if (!sck_q && !sck) paused <= ~hold_n;
    end
  end
endmodule

// File: rtl/pot_so_shift.sv
`timescale 1ns/1ps
module pot_so_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         so_bit
);
  logic [W-1:0] out_sr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_sr <= '0;
      so_bit <= 1'b0;
    end else if (load) begin
      out_sr <= load_val;
    end else if (shift) begin
      so_bit <= out_sr[W-1];
      out_sr <= {out_sr[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/pot_spi_cmd_decoder.sv
`timescale 1ns/1ps
module pot_spi_cmd_decoder
  import pot_cmd_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0101,
  parameter int STRAP_W = 2,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               si,
  input  logic               hold_n,
  input  logic               wip,
  input  logic [7:0]         rd_data,
  output logic               so_bit,
  output logic               so_en,
  output logic               rd_req,
  output logic [3:0]         sel_op,
  output logic [1:0]         sel_chan,
  output logic [1:0]         sel_dreg,
  output logic               cmd_valid,
  output logic [7:0]         cmd_wdata,
  output logic               step_valid,
  output logic               step_up
);
  localparam logic [CNT_W-1:0] ID_LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] OP_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] OUT_FIRST = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] OUT_LAST = CNT_W'(FULL_BITS - 1);
  localparam logic [7:0] ID_BYTE = {DEV_TYPE, {(4-STRAP_W){1'b0}}, {STRAP_W{1'b0}}};

  logic cs_fall, cs_rise, sck_rise, sck_fall, armed, paused;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0] sr, next_byte, id_want;
  logic id_ok, rd_frame, step_frame, rd_pend;
  logic op_done, stat_go, so_load, so_shift_en;
  logic [7:0] so_val;

  pot_spi_pins u_pins (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .armed(armed), .paused(paused)
  );

  assign next_byte = {sr[6:0], si};
  assign id_want   = ID_BYTE | {{(8-STRAP_W){1'b0}}, strap};
  assign op_done   = sck_rise && (bit_cnt == OP_LAST) && id_ok;
  assign stat_go   = op_done && (next_byte[7:4] == OP_STATUS);
  assign so_load   = rd_pend | stat_go;
  assign so_val    = rd_pend ? rd_data : {7'b0, wip};
  assign so_shift_en = sck_fall && rd_frame &&
                       (bit_cnt >= OUT_FIRST) && (bit_cnt <= OUT_LAST);

  pot_so_shift #(.W(BYTE_W)) u_so (
    .clk(clk), .rst(rst), .clr(cs_fall), .load(so_load),
    .load_val(so_val), .shift(so_shift_en), .so_bit(so_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      sr         <= '0;
      id_ok      <= 1'b0;
      rd_frame   <= 1'b0;
      step_frame <= 1'b0;
      rd_pend    <= 1'b0;
      rd_req     <= 1'b0;
      sel_op     <= '0;
      sel_chan   <= '0;
      sel_dreg   <= '0;
      cmd_valid  <= 1'b0;
      cmd_wdata  <= '0;
      step_valid <= 1'b0;
      step_up    <= 1'b0;
      so_en      <= 1'b0;
    end else begin
      rd_req     <= 1'b0;
      cmd_valid  <= 1'b0;
      step_valid <= 1'b0;
      rd_pend    <= rd_req;
      so_en      <= ~cs_n & rd_frame & ~paused;
      if (cs_fall) begin
        bit_cnt    <= '0;
        id_ok      <= 1'b0;
        rd_frame   <= 1'b0;
        step_frame <= 1'b0;
      end else if (sck_rise) begin
        sr <= next_byte;
        if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == ID_LAST) id_ok <= (next_byte == id_want);
        if (op_done) begin
          sel_op     <= next_byte[7:4];
          sel_dreg   <= next_byte[3:2];
          sel_chan   <= next_byte[1:0];
          rd_req     <= is_fetch(next_byte[7:4]);
          rd_frame   <= is_fetch(next_byte[7:4]) || (next_byte[7:4] == OP_STATUS);
          step_frame <= (next_byte[7:4] == OP_STEP);
        end
        if (step_frame) begin
          step_valid <= 1'b1;
          step_up    <= si;
        end
      end
      if (cs_rise && armed && id_ok && is_store(sel_op) &&
          (bit_cnt == CNT_W'(store_bits(sel_op)))) begin
        cmd_valid <= 1'b1;
        cmd_wdata <= sr;
      end
    end
  end
endmodule

// File: rtl/pot_spi_cmd_decoder_chk.sv
`timescale 1ns/1ps
module pot_spi_cmd_decoder_chk
  import pot_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       sck,
  input logic       so_en,
  input logic       rd_req,
  input logic [3:0] sel_op,
  input logic       cmd_valid,
  input logic       step_valid
);
  // R11: deselect turns the output driver off within one clock
  p_so_off_deselect_r11: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> !so_en);

  // R4 / R5: command strobes follow chip-select rise and only for store opcodes
  p_store_on_cs_rise_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (is_store(sel_op) && $past(cs_n)));

  // R6: read requests only for fetch opcodes, right after an SCK rising edge
  p_fetch_on_sck_r6: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (is_fetch(sel_op) && $past(sck)));

  // R8: step pulses only in stepping frames, on SCK high with the chip selected
  p_step_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
    step_valid |-> ((sel_op == OP_STEP) && $past(sck) && !$past(cs_n)));

  // R9: strobe kinds never overlap
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_valid, rd_req, step_valid}));
endmodule

bind pot_spi_cmd_decoder pot_spi_cmd_decoder_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .so_en(so_en),
  .rd_req(rd_req), .sel_op(sel_op), .cmd_valid(cmd_valid),
  .step_valid(step_valid)
);

// File: tb/pot_spi_cmd_decoder_test.sv
`timescale 1ns/1ps
module pot_spi_cmd_decoder_test;
  localparam int H = 5;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wip = 1'b0;
  logic [7:0] rd_data;
  logic so_bit, so_en, rd_req, cmd_valid, cmd_wdata_unused, step_valid, step_up;
  logic [3:0] sel_op;
  logic [1:0] sel_chan, sel_dreg;
  logic [7:0] cmd_wdata;

  int n_chk = 0, n_bad = 0;
  int n_cmd = 0, n_rd = 0, n_up = 0, n_dn = 0;
  logic [3:0] m_op;
  logic [1:0] m_chan, m_dreg;
  logic [7:0] m_wdata;
  logic [7:0] rx;
  logic en_all;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pot_spi_cmd_decoder uut (
    .clk(clk), .rst(rst), .strap(STRAP), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wip(wip), .rd_data(rd_data), .so_bit(so_bit),
    .so_en(so_en), .rd_req(rd_req), .sel_op(sel_op), .sel_chan(sel_chan),
    .sel_dreg(sel_dreg), .cmd_valid(cmd_valid), .cmd_wdata(cmd_wdata),
    .step_valid(step_valid), .step_up(step_up)
  );
  assign cmd_wdata_unused = 1'b0;

  function automatic logic [7:0] bank_fn(logic [3:0] op, logic [1:0] ch, logic [1:0] dr);
    return (op == 4'b1001) ? {4'hA, 2'b01, ch} : {4'h3, dr, ch} ^ 8'h80;
  endfunction

  // Register bank model: one clock of read latency.
  always @(posedge clk) if (rd_req) rd_data <= bank_fn(sel_op, sel_chan, sel_dreg);

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_cmd++; m_op = sel_op; m_chan = sel_chan; m_dreg = sel_dreg; m_wdata = cmd_wdata;
    end
    if (rd_req) n_rd++;
    if (step_valid) begin
      if (step_up) n_up++; else n_dn++;
      m_chan = sel_chan;
    end
  end

  function automatic int b_len(logic [3:0] op);
    case (op)
      4'b1010, 4'b1100: return 24;
      4'b1101, 4'b1110, 4'b0001, 4'b1000: return 16;
      default: return 0;
    endcase
  endfunction
  function automatic bit b_fetch(logic [3:0] op);
    return op == 4'b1001 || op == 4'b1011;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [63:0] bits, input int n, input int hold_at);
    cs_n = 1'b0; wait_clk(3);
    rx = 8'h00; en_all = 1'b1;
    for (int i = 0; i < n; i++) begin
      si = bits[n-1-i]; sck = 1'b0; wait_clk(H);
      if (i >= 16 && i < 24) begin rx = {rx[6:0], so_bit}; en_all &= so_en; end
      if (i == hold_at) begin
        hold_n = 1'b0; wait_clk(2);
        for (int k = 0; k < 3; k++) begin
          si = ~si; sck = 1'b1; wait_clk(2); sck = 1'b0; wait_clk(2);
        end
        check("R10 so_en during pause", so_en, 0);
        si = bits[n-1-i]; hold_n = 1'b1; wait_clk(2);
      end
      sck = 1'b1; wait_clk(H);
    end
    sck = 1'b0; wait_clk(H);
    cs_n = 1'b1; wait_clk(3);
  endtask

  task automatic run_frame(input logic [7:0] id, input logic [3:0] op, input logic [1:0] dr,
                           input logic [1:0] ch, input logic [7:0] data, input int n,
                           input logic [39:0] tail, input int hold_at);
    logic [63:0] full, bits;
    int c0, r0, u0, d0, eu, ed;
    bit idok, exp_cmd, exp_rd, exp_stat, legal;
    string tag;
    full = {40'b0, id, op, dr, ch, data};
    bits = (n <= 24) ? (full >> (24 - n)) : ((full << (n - 24)) | {24'b0, tail});
    idok = (id == {4'b0101, 2'b00, STRAP});
    legal = (b_len(op) != 0) || b_fetch(op) || op == 4'b0101 || op == 4'b0010;
    tag = !idok ? "R2" : !legal ? "R9" : "";
    c0 = n_cmd; r0 = n_rd; u0 = n_up; d0 = n_dn;
    xfer(bits, n, hold_at);
    exp_cmd  = idok && b_len(op) != 0 && n == b_len(op);
    exp_rd   = idok && b_fetch(op) && n >= 16;
    exp_stat = idok && op == 4'b0101 && n >= 24;
    eu = 0; ed = 0;
    if (idok && op == 4'b0010)
      for (int k = 0; k < n - 16; k++) if (bits[k]) eu++; else ed++;
    check({tag, (b_len(op) == 24) ? " R4" : " R5", " cmd count"}, n_cmd - c0, exp_cmd);
    if (exp_cmd) begin
      check("R3 opcode", m_op, op);
      check("R3 channel", m_chan, ch);
      check("R3 dreg", m_dreg, dr);
      if (n == 24) check("R4 wdata", m_wdata, data);
    end
    check({tag, " R6 rd count"}, n_rd - r0, exp_rd);
    if (exp_rd && n >= 24) begin
      check("R6 read byte", rx, bank_fn(op, ch, dr));
      check("R11 so_en in data", en_all, 1);
    end
    if (exp_stat) begin
      check("R7 status byte", rx, {7'b0, wip});
      check("R11 so_en in status", en_all, 1);
    end
    check({tag, " R8 step up"}, n_up - u0, eu);
    check({tag, " R8 step down"}, n_dn - d0, ed);
    if (eu + ed > 0) check("R8 step chan", m_chan, ch);
    check("R11 so_en after deselect", so_en, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  localparam logic [7:0] GOOD_ID = {4'b0101, 2'b00, STRAP};

  initial begin
    logic [3:0] ops [12];
    logic [39:0] tail;
    int n, pick;
    logic [7:0] id;
    void'($urandom(32'h5EED));
    ops = '{4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1101, 4'b1110,
            4'b0001, 4'b1000, 4'b0010, 4'b0101, 4'b0000, 4'b1111};
    cs_n = 1'b0;
    wait_clk(5);
    check("R1 so_en reset", so_en, 0);
    check("R1 cmd_valid reset", cmd_valid, 0);
    check("R1 rd_req reset", rd_req, 0);
    check("R1 step_valid reset", step_valid, 0);
    rst = 1'b0; wait_clk(2);
    // R1: select held low through reset: frame must be ignored
    xfer({40'b0, GOOD_ID, 4'b1010, 4'b0001, 8'h5A}, 24, -1);
    check("R1 no arm cmd", n_cmd, 0);
    wait_clk(4);
    // directed corner cases
    run_frame(GOOD_ID, 4'b1010, 2'b00, 2'b11, 8'hC3, 24, 0, -1);
    run_frame(GOOD_ID, 4'b1100, 2'b10, 2'b01, 8'h3C, 24, 0, -1);
    run_frame(GOOD_ID, 4'b1100, 2'b10, 2'b01, 8'h3C, 23, 0, -1);
    run_frame(GOOD_ID, 4'b1010, 2'b01, 2'b01, 8'h11, 25, 40'h1, -1);
    run_frame(GOOD_ID, 4'b1101, 2'b11, 2'b10, 8'h00, 16, 0, -1);
    run_frame(GOOD_ID, 4'b1110, 2'b11, 2'b10, 8'h00, 24, 0, -1);
    run_frame(GOOD_ID, 4'b1011, 2'b10, 2'b11, 8'h00, 24, 0, -1);
    run_frame(GOOD_ID, 4'b1001, 2'b00, 2'b10, 8'h00, 24, 0, 19);
    run_frame(GOOD_ID, 4'b1010, 2'b00, 2'b00, 8'h96, 24, 0, 10);
    wip = 1'b1;
    run_frame(GOOD_ID, 4'b0101, 2'b00, 2'b01, 8'h00, 24, 0, -1);
    wip = 1'b0;
    run_frame(GOOD_ID, 4'b0010, 2'b00, 2'b01, 8'hA5, 26, 40'h2, -1);
    run_frame({4'b0111, 2'b00, STRAP}, 4'b1010, 2'b00, 2'b00, 8'h77, 24, 0, -1);
    run_frame({4'b0101, 2'b00, ~STRAP}, 4'b1011, 2'b00, 2'b00, 8'h00, 24, 0, -1);
    run_frame(GOOD_ID, 4'b0000, 2'b00, 2'b00, 8'h12, 24, 0, -1);
    run_frame(GOOD_ID, 4'b1111, 2'b00, 2'b00, 8'h00, 16, 0, -1);
    // random frames
    for (int t = 0; t < 60; t++) begin
      pick = $urandom % 12;
      id = ($urandom % 6 == 0) ? GOOD_ID ^ (8'h1 << ($urandom % 8)) : GOOD_ID;
      wip = $urandom % 2;
      case ($urandom % 4)
        0: n = 16;
        1: n = 23 + ($urandom % 3);
        default: n = (b_len(ops[pick]) != 0) ? b_len(ops[pick]) : 24;
      endcase
      tail = {$urandom, $urandom};
      if (ops[pick] == 4'b0010) n = 16 + ($urandom % 41);
      if (n > 24) tail = tail & ((40'h1 << (n - 24)) - 40'h1); else tail = '0;
      run_frame(id, ops[pick], 2'($urandom), 2'($urandom), 8'($urandom), n, tail,
                ($urandom % 8 == 0) ? 5 + ($urandom % 10) : -1);
    end
    finish_run();
  end
endmodule